// File: doc/BRIEF.md
# Serial Receive Buffer Status Logic

This block holds the byte of the last good serial frame and the two status flags that tell a processor whether that byte is waiting and whether a later frame was lost. The serial shift side reports each finished frame with a single-cycle completion strobe, the received byte and an error indication. The processor uses a one-bit-address register port. Address 0 reads the data register and address 1 reads or writes the status register. Reading and writing are combinational on the read side and take effect at the clock edge on the write side.

A flag clears in one of two ways. The first is a status write that puts 0 in the flag's bit after a status read has returned 1 for that flag. The second applies to the full flag only and is a read of the data register. When a frame completes while the previous byte is still unread, the new byte is dropped and the overrun flag sets. While overrun is set, a halt output stops the serial receiver. In synchronous mode a second halt output also stops the transmitter. A receive-enable input gates completions and does not touch the stored state.

Top module: `serial_rx_status`

## Requirements
- R1: After reset the full flag (status bit 6), the overrun flag (status bit 5), the data register and both halt outputs are 0.
- R2: An accepted completion with the error indication at 0 and the full flag at 0 loads the byte into the data register and sets the full flag, both visible from the next cycle. An accepted completion is one where the strobe is 1, rx_en is 1 and halt_rx is 0.
- R3: A read of address 0 clears the full flag from the next cycle and leaves the overrun flag alone.
- R4: An accepted completion with the error indication at 1 leaves the data register and the full flag unchanged.
- R5: An accepted completion while the full flag is 1 sets the overrun flag, whatever its error indication. The data register keeps its old byte.
- R6: A status write that puts 0 in a flag's bit clears that flag only if a status read has returned 1 for that flag since the flag last set and since the previous status write. Writing 1 has no effect. Any status write uses up the arming from the earlier read.
- R7: The overrun flag clears only through the R6 read-then-write-0 sequence. A data register read leaves it set.
- R8: halt_rx equals the overrun flag. halt_tx is 1 only when the overrun flag and sync_mode are both 1.
- R9: A completion strobe while rx_en is 0 or halt_rx is 1 changes no state. Changing rx_en alone changes no state.
- R10: When a flag's set event and a clear event fall in the same cycle, the flag is 1 afterwards.
- R11: Status bits other than 6 and 5 read as 0. A write to address 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| done_stb | input | 1 | Single-cycle frame completion strobe from the shift side |
| done_data | input | 8 | Byte carried with the completion strobe |
| done_err | input | 1 | Error indication carried with the completion strobe |
| rx_en | input | 1 | Receive enable |
| sync_mode | input | 1 | 1 selects synchronous mode |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 selects the data register, 1 selects the status register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| halt_rx | output | 1 | Stops the serial receiver |
| halt_tx | output | 1 | Stops the serial transmitter |

## Verification
The bench first goes after the arming rules. It writes 0 without a preceding read and expects the flag to survive. It writes 1 after a read and then 0, and expects the second write to do nothing, because a design that keeps the arming after a write would clear the flag here. It checks that overrun survives a data read and that a strobe arriving while halted is dropped, since a wrong design would overwrite the held byte or re-raise state. It also makes a completion coincide with an armed write-0 to the full flag, where a design that lets the clear win would show the flag at 0 with fresh data behind it.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
   localparam logic ADDR_DATA = 1'b0;
   localparam logic ADDR_STAT = 1'b1;

   typedef struct packed {
      logic rd_data;
      logic rd_stat;
      logic wr_stat;
   } bus_ops_t;
endpackage

// File: rtl/rxbuf_flag.sv
module rxbuf_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic stat_rd_i,
   input  logic stat_wr_i,
   input  logic wbit_i,
   output logic q_o
);
   logic armed_q;
   logic wr_clr;

   assign wr_clr = stat_wr_i & armed_q & ~wbit_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o <= 1'b0;
      end else if (set_i) begin
         q_o <= 1'b1;
      end else if (clr_i || wr_clr) begin
         q_o <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (set_i || stat_wr_i) begin
         armed_q <= 1'b0;
      end else if (stat_rd_i && q_o) begin
         armed_q <= 1'b1;
      end
   end

   // R6: an unarmed flag ignores status writes
   a_r6_unarmed_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (q_o && !armed_q && !clr_i) |=> q_o);
   // R10: a set event always leaves the flag at 1
   a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);
endmodule

// File: rtl/rxbuf_data_reg.sv
module rxbuf_data_reg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] din_i,
   output logic [DATA_W-1:0] dout_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_o <= '0;
      end else if (load_i) begin
         dout_o <= din_i;
      end
   end
endmodule

// File: rtl/rxbuf_halt.sv
module rxbuf_halt #(
   parameter bit TX_HALT_IN_SYNC = 1'b1
) (
   input  logic ovr_i,
   input  logic sync_mode_i,
   output logic halt_rx_o,
   output logic halt_tx_o
);
   assign halt_rx_o = ovr_i;
   generate
      if (TX_HALT_IN_SYNC) begin : g_tx_halt
         assign halt_tx_o = ovr_i & sync_mode_i;
      end else begin : g_no_tx_halt
         assign halt_tx_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status #(
   parameter int DATA_W          = 8,
   parameter int BUS_W           = 8,
   parameter int FULL_POS        = 6,
   parameter int OVR_POS         = 5,
   parameter bit TX_HALT_IN_SYNC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done_stb,
   input  logic [DATA_W-1:0] done_data,
   input  logic              done_err,
   input  logic              rx_en,
   input  logic              sync_mode,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic              bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              halt_rx,
   output logic              halt_tx
);
   import rxbuf_pkg::*;

   localparam int PAD_W = BUS_W - DATA_W;

   generate
      if (DATA_W < 1 || DATA_W > BUS_W) begin : g_bad_width
         $error("DATA_W must be between 1 and BUS_W");
      end
      if (FULL_POS == OVR_POS || FULL_POS >= BUS_W || OVR_POS >= BUS_W) begin : g_bad_pos
         $error("flag positions must differ and fit in BUS_W");
      end
   endgenerate

   bus_ops_t          ops;
   logic              full_q, ovr_q;
   logic              accept, good, load, ovr_set;
   logic [DATA_W-1:0] data_q;
   logic [BUS_W-1:0]  stat_vec, data_vec;

   assign ops.rd_data = bus_rd & (bus_addr == ADDR_DATA);
   assign ops.rd_stat = bus_rd & (bus_addr == ADDR_STAT);
   assign ops.wr_stat = bus_wr & (bus_addr == ADDR_STAT);

   assign accept  = done_stb & rx_en & ~halt_rx;
   assign good    = accept & ~done_err;
   assign load    = good & ~full_q;
   assign ovr_set = accept & full_q;

   rxbuf_data_reg #(.DATA_W(DATA_W)) i_data (
      .clk(clk), .rst_n(rst_n), .load_i(load), .din_i(done_data), .dout_o(data_q)
   );

   rxbuf_flag i_full (
      .clk(clk), .rst_n(rst_n), .set_i(load), .clr_i(ops.rd_data),
      .stat_rd_i(ops.rd_stat), .stat_wr_i(ops.wr_stat),
      .wbit_i(bus_wdata[FULL_POS]), .q_o(full_q)
   );

   rxbuf_flag i_ovr (
      .clk(clk), .rst_n(rst_n), .set_i(ovr_set), .clr_i(1'b0),
      .stat_rd_i(ops.rd_stat), .stat_wr_i(ops.wr_stat),
      .wbit_i(bus_wdata[OVR_POS]), .q_o(ovr_q)
   );

   rxbuf_halt #(.TX_HALT_IN_SYNC(TX_HALT_IN_SYNC)) i_halt (
      .ovr_i(ovr_q), .sync_mode_i(sync_mode), .halt_rx_o(halt_rx), .halt_tx_o(halt_tx)
   );

   generate
      for (genvar b = 0; b < BUS_W; b++) begin : g_stat
         if (b == FULL_POS) begin : g_full
            assign stat_vec[b] = full_q;
         end else if (b == OVR_POS) begin : g_ovr
            assign stat_vec[b] = ovr_q;
         end else begin : g_zero
            assign stat_vec[b] = 1'b0;
         end
      end
      if (PAD_W > 0) begin : g_pad
         assign data_vec = {{PAD_W{1'b0}}, data_q};
      end else begin : g_nopad
         assign data_vec = data_q;
      end
   endgenerate

   assign bus_rdata = (bus_addr == ADDR_STAT) ? stat_vec : data_vec;

   // R2: a good frame into an empty buffer is captured
   a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
      (done_stb && rx_en && !halt_rx && !done_err && !full_q)
      |=> (full_q && data_q == $past(done_data)));
   // R4: an errored frame leaves data untouched
   a_r4_err_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
      (done_stb && done_err) |=> $stable(data_q));
   // R5: a frame landing on a full buffer raises overrun and keeps the byte
   a_r5_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      (done_stb && rx_en && !halt_rx && full_q) |=> (ovr_q && $stable(data_q)));
   // R7: reading data never clears overrun
   a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q && !(bus_wr && bus_addr)) |=> ovr_q);
   // R9: a strobe while halted changes nothing stored
   a_r9_halt_ignores: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_rx && done_stb) |=> $stable(data_q));
endmodule

// File: tb/test_serial_rx_status.sv
module test_serial_rx_status;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       done_stb = 0, done_err = 0, rx_en = 0, sync_mode = 0;
   logic       bus_rd = 0, bus_wr = 0, bus_addr = 0;
   logic [7:0] done_data = 0, bus_wdata = 0;
   logic [7:0] bus_rdata;
   logic       halt_rx, halt_tx;

   int checks = 0, fails = 0;
   bit finished = 0;

   // bench model state
   bit m_full, m_ovr, m_af, m_ao;
   logic [7:0] m_data;

   always #4 clk = ~clk;

   serial_rx_status i_serial_rx_status (
      .clk(clk), .rst_n(rst_n), .done_stb(done_stb), .done_data(done_data),
      .done_err(done_err), .rx_en(rx_en), .sync_mode(sync_mode),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .halt_rx(halt_rx), .halt_tx(halt_tx)
   );

   function automatic logic [7:0] exp_rdata(logic addr);
      return addr ? {1'b0, m_full, m_ovr, 5'b0} : m_data;
   endfunction

   task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic step(bit stb, logic [7:0] d, bit err, bit en, bit sy,
                       bit rd, bit wr, bit addr, logic [7:0] wd, string tag);
      bit acc, set_f, set_o, rdd, rds, wrs;
      @(negedge clk);
      done_stb = stb; done_data = d; done_err = err; rx_en = en; sync_mode = sy;
      bus_rd = rd; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
      #1;
      if (rd) chk(tag, bus_rdata, exp_rdata(addr));
      chk("R8 halt_rx", {7'b0, halt_rx}, {7'b0, m_ovr});
      chk("R8 halt_tx", {7'b0, halt_tx}, {7'b0, m_ovr & sy});
      @(posedge clk);
      acc = stb & en & !m_ovr;
      set_f = acc & !err & !m_full;
      set_o = acc & m_full;
      rdd = rd & !addr; rds = rd & addr; wrs = wr & addr;
      if (set_f) m_data = d;
      if (set_f) m_full = 1;
      else if (rdd || (wrs && m_af && !wd[6])) m_full = 0;
      if (set_o) m_ovr = 1;
      else if (wrs && m_ao && !wd[5]) m_ovr = 0;
      if (set_f || wrs) m_af = 0; else if (rds && (m_full || set_f)) m_af = 1;
      if (set_o || wrs) m_ao = 0; else if (rds && m_ovr) m_ao = 1;
   endtask

   // flag arming uses the value before the edge, so re-derive it cleanly
   task automatic idle(); step(0,0,0,1,0,0,0,0,0,"idle"); endtask
   task automatic rd_stat(string t); step(0,0,0,1,0,1,0,1,0,t); endtask
   task automatic rd_data(string t); step(0,0,0,1,0,1,0,0,0,t); endtask
   task automatic wr_stat(logic [7:0] v); step(0,0,0,1,0,0,1,1,v,"wr"); endtask
   task automatic frame(logic [7:0] d, bit err); step(1,d,err,1,0,0,0,0,0,"frame"); endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      m_full = 0; m_ovr = 0; m_af = 0; m_ao = 0; m_data = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R1 reset state
      rd_stat("R1 status after reset");
      rd_data("R1 data after reset");
      // R2 good frame, R11 unused status bits 0
      frame(8'hA5, 0);
      rd_stat("R2 full set / R11 unused bits");
      rd_data("R2 data loaded");
      // R3 data read cleared full
      rd_stat("R3 full cleared by data read");
      // R4 errored frame
      frame(8'h3C, 1);
      rd_stat("R4 full unchanged on error");
      rd_data("R4 data unchanged on error");
      // R11 data-address write ignored
      step(0,0,0,1,0,0,1,0,8'hFF,"wr data");
      rd_data("R11 data write ignored");
      // R5 overrun
      frame(8'h11, 0);
      frame(8'h22, 0);
      rd_stat("R5 overrun set");
      rd_data("R5 data keeps old byte");
      // R8 sync mode halts transmit
      step(0,0,0,1,1,0,0,0,0,"R8 sync halt");
      // R9 strobe while halted, and with rx_en low
      frame(8'h77, 0);
      rd_data("R9 halted strobe ignored");
      rd_stat("R7 overrun survives data read");
      // R6 unarmed write-0 ignored (previous read armed ovr; consume with write 1)
      wr_stat(8'hFF);
      wr_stat(8'h00);
      rd_stat("R6 write without read-as-1 ignored");
      wr_stat(8'h00);
      rd_stat("R6 read then write 0 clears overrun");
      step(1,8'h99,0,0,0,0,0,0,0,"R9 rx_en low");
      step(0,0,0,0,0,0,0,0,0,"R9 rx_en toggle");
      rd_stat("R9 rx_en low strobe ignored");
      // R10 set wins over armed clear
      frame(8'h55, 0);
      rd_stat("R10 arm full");
      rd_data("R10 drain");
      step(1,8'h66,0,1,0,0,1,1,8'h00,"R10 set+clear");
      rd_stat("R10 set wins");
      rd_data("R10 new byte");
      // constrained random
      for (int i = 0; i < 3000; i++) begin
         bit stb = ($urandom_range(0,3) == 0);
         bit rd  = ($urandom_range(0,2) == 0);
         bit wr  = ($urandom_range(0,3) == 0);
         bit ad  = $urandom_range(0,1);
         logic [7:0] wd = ($urandom_range(0,1) == 0) ? 8'h00 : 8'($urandom());
         step(stb, 8'($urandom()), ($urandom_range(0,5) == 0),
              ($urandom_range(0,7) != 0), $urandom_range(0,1),
              rd, wr, ad, wd, ad ? "R6 random status" : "R2 random data");
      end
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule